// File: doc/BRIEF.md
# Serial Configuration Slave with Command Pointer

This block is the configuration port of a front-end readout chip. It is a slave on a two-wire I2C bus with a 7-bit address, and it runs entirely from a faster system clock. It synchronises SCL and SDA, finds START and STOP conditions and clock edges, and pulls SDA low through an open-drain output enable. The upper three address bits are fixed at `001`. The lower four come from strap inputs. The strap value `1111` is a broadcast address that every chip on the bus accepts.

Each access goes through an 8-bit command pointer. Bits [7:1] name one of the target registers and bit 0 gives the direction. The target registers are the error register, the mode register, the latency register and eleven bias words.

- **Write:** one transfer carries the address byte, a command byte with bit 0 cleared, and the new value.
- **Read:** a write transfer first loads the pointer with bit 0 set. A separate read transfer then returns one byte. The pointer stays loaded, so the same register can be read again and again.

The stored registers drive outputs to the analogue core. The error register shows two fault inputs in active-low form. Because of this, a broadcast read, where the open-drain outputs of all chips combine as a wired AND, shows a 0 whenever any chip has a fault.

Top module: `cfg_i2c_slave`

## Requirements
- R1: After reset, the mode output is 3'b100 (bit 2 calibration inhibit set, bit 1 peak clear, bit 0 bias enable clear), the latency output is 8'h84, all bias words are 0, and SDA is released.
- R2: The slave answers an address byte whose bits [7:5] are 001 and whose bits [4:1] equal the strap value. It acknowledges by pulling SDA low during the ninth clock. It also acknowledges every later byte it accepts in that transfer.
- R3: A write transfer of address (bit 0 = 0), command byte (bit 0 = 0) and data byte stores the data byte in the register that command bits [7:1] select.
- R4: For an address with the wrong prefix or a foreign strap value, the slave does not acknowledge. It also ignores the rest of the transfer: no register changes and SDA stays released.
- R5: A command byte with bit 0 = 1 loads the pointer for reading. Any further bytes in that write transfer are acknowledged but change no register.
- R6: A read transfer (address bit 0 = 1) returns, MSB first, the byte of the register the pointer selects. After that byte the slave releases SDA.
- R7: The pointer persists across transfers, so consecutive read transfers return the same register without a new command byte.
- R8: Command bits [7:1] map as follows: 7'h00 selects the error register, 7'h01 the mode register, 7'h02 the latency register, and 7'h20+k selects bias word k (k = 0..10). Bias word k appears on bias_q[8k+7:8k].
- R9: A mode write stores data bits [2:0] only. A mode read returns those three bits with bits [7:3] zero.
- R10: An error read returns bit 1 = NOT fifo_err, bit 0 = NOT lat_err and bits [7:2] zero. Writes to the error code have no effect.
- R11: The strap pattern 1111 in the address is accepted by every slave, so one broadcast write updates all of them.
- R12: When several slaves answer a broadcast read, the bus carries the bitwise AND of their bytes.
- R13: A command code outside the R8 map stores nothing on a write and reads back as 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad (resolved bus) |
| strap_id | input | 4 | Bonded chip identifier, lower four address bits |
| fifo_err | input | 1 | Address queue overflow fault, active high |
| lat_err | input | 1 | Pointer separation fault, active high |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| mode_q | output | 3 | Mode register: calibration inhibit, peak select, bias enable |
| latency_q | output | 8 | Latency register |
| bias_q | output | NUM_BIAS*8 | Bias words, word k in bits [8k+7:8k] |

## Verification
The hardest case to reach from the ports is the wired-AND readback. A single slave can never show it, because it only appears when two slaves hold different values and both drive the same line at the same bit times. The bench therefore places two slaves with different straps on one resolved SDA net. It writes each one separately so that their bias words differ bit by bit. It then loads a shared pointer with a broadcast command and reads with the broadcast address, expecting the AND of the two modelled values. It also reads each chip on its own afterwards, to show that neither register was disturbed.

// File: rtl/cfg_i2c_pkg.sv
// Shared constants and types for the serial configuration slave.
// Assumes 8-bit bytes and 7-bit register selectors.
package cfg_i2c_pkg;
    localparam int BYTE_W = 8;
    localparam int SEL_W  = 7;
    localparam int ID_W   = 4;

    localparam logic [2:0]       ADDR_PREFIX = 3'b001;
    localparam logic [ID_W-1:0]  ID_ALL      = 4'b1111;

    localparam logic [SEL_W-1:0] SEL_ERR   = 7'h00;
    localparam logic [SEL_W-1:0] SEL_MODE  = 7'h01;
    localparam logic [SEL_W-1:0] SEL_LAT   = 7'h02;
    localparam logic [SEL_W-1:0] SEL_BIAS0 = 7'h20;

    localparam logic [2:0]        MODE_INIT = 3'b100;
    localparam logic [BYTE_W-1:0] LAT_INIT  = 8'h84;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_SKIP
    } bus_state_e;
endpackage

// File: rtl/cfg_i2c_sync.sv
// Input conditioner: synchronises SCL and SDA into the clk domain and
// flags SCL edges plus START/STOP conditions.
// Assumes clk is several times faster than SCL; STAGES >= 2.
module cfg_i2c_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_d;
    logic              sda_d;

    // Synchroniser chains, idle-high after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
    end

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    // One-cycle history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    // Edge and bus-condition decode.
    always_comb begin
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/cfg_i2c_engine.sv
// Byte-level protocol engine: address match, acknowledge, command pointer,
// write strobe and single-byte read shifting.
// Assumes conditioned inputs from cfg_i2c_sync; rd_data is combinational
// from the register file and is sampled when the address is acknowledged.
module cfg_i2c_engine
    import cfg_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [ID_W-1:0]   strap_id,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] cmd_q,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_data
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    bus_state_e        state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [1:0]        byte_idx;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              rw_q;
    logic              oe_q;
    logic              addr_hit;

    // Address byte decode: fixed prefix plus own or broadcast identifier.
    always_comb begin
        addr_hit = (rx_sh[7:5] == ADDR_PREFIX) &&
                   ((rx_sh[4:1] == strap_id) || (rx_sh[4:1] == ID_ALL));
    end

    // Protocol state machine, all actions on conditioned SCL edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            byte_idx <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            rw_q     <= 1'b0;
            oe_q     <= 1'b0;
            cmd_q    <= '0;
            wr_stb   <= 1'b0;
            wr_data  <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (start_det) begin
                state    <= ST_RX;
                bit_cnt  <= '0;
                byte_idx <= '0;
                oe_q     <= 1'b0;
            end else if (stop_det) begin
                state <= ST_IDLE;
                oe_q  <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise && bit_cnt != CNT_FULL) begin
                            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == CNT_FULL) begin
                            if (byte_idx != 2'd3) begin
                                byte_idx <= byte_idx + 1'b1;
                            end
                            case (byte_idx)
                                2'd0: begin
                                    if (addr_hit) begin
                                        rw_q  <= rx_sh[0];
                                        oe_q  <= 1'b1;
                                        state <= ST_ACK;
                                    end else begin
                                        state <= ST_SKIP;
                                    end
                                end
                                2'd1: begin
                                    cmd_q <= rx_sh;
                                    oe_q  <= 1'b1;
                                    state <= ST_ACK;
                                end
                                2'd2: begin
                                    wr_stb  <= ~cmd_q[0];
                                    wr_data <= rx_sh;
                                    oe_q    <= 1'b1;
                                    state   <= ST_ACK;
                                end
                                default: begin
                                    oe_q  <= 1'b1;
                                    state <= ST_ACK;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (rw_q) begin
                                tx_sh <= rd_data;
                                oe_q  <= ~rd_data[BYTE_W-1];
                                state <= ST_TX;
                            end else begin
                                oe_q  <= 1'b0;
                                state <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bit_cnt == CNT_LAST) begin
                                oe_q  <= 1'b0;
                                state <= ST_TX_ACK;
                            end else begin
                                tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
                                oe_q    <= ~tx_sh[BYTE_W-2];
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) begin
                            state <= ST_SKIP;
                        end
                    end
                    default: begin
                        oe_q <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign sda_oe = oe_q;
endmodule

// File: rtl/cfg_i2c_regfile.sv
// Configuration register file: mode, latency and bias words plus the
// read multiplexer with the active-low error view.
// Assumes wr_sel is stable while wr_stb is high; fault inputs are in clk domain.
module cfg_i2c_regfile
    import cfg_i2c_pkg::*;
#(
    parameter int NUM_BIAS = 11
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_stb,
    input  logic [SEL_W-1:0]           wr_sel,
    input  logic [BYTE_W-1:0]          wr_data,
    input  logic [SEL_W-1:0]           rd_sel,
    input  logic                       fifo_err,
    input  logic                       lat_err,
    output logic [2:0]                 mode_q,
    output logic [BYTE_W-1:0]          latency_q,
    output logic [NUM_BIAS*BYTE_W-1:0] bias_flat,
    output logic [BYTE_W-1:0]          rd_data
);
    // Mode register: only three bits stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_INIT;
        end else if (wr_stb && wr_sel == SEL_MODE) begin
            mode_q <= wr_data[2:0];
        end
    end

    // Latency register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latency_q <= LAT_INIT;
        end else if (wr_stb && wr_sel == SEL_LAT) begin
            latency_q <= wr_data;
        end
    end

    // One bias word per consecutive selector above SEL_BIAS0.
    for (genvar gi = 0; gi < NUM_BIAS; gi++) begin : g_bias
        localparam logic [SEL_W-1:0] MY_SEL = SEL_BIAS0 + SEL_W'(gi);
        logic [BYTE_W-1:0] word_q;

        // Bias word storage.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (wr_stb && wr_sel == MY_SEL) begin
                word_q <= wr_data;
            end
        end

        assign bias_flat[gi*BYTE_W +: BYTE_W] = word_q;
    end

    // Read multiplexer; unknown selectors read as zero.
    always_comb begin
        rd_data = '0;
        case (rd_sel)
            SEL_ERR:  rd_data = {{(BYTE_W-2){1'b0}}, ~fifo_err, ~lat_err};
            SEL_MODE: rd_data = {{(BYTE_W-3){1'b0}}, mode_q};
            SEL_LAT:  rd_data = latency_q;
            default: begin
                for (int k = 0; k < NUM_BIAS; k++) begin
                    if (rd_sel == SEL_BIAS0 + SEL_W'(k)) begin
                        rd_data = bias_flat[k*BYTE_W +: BYTE_W];
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/cfg_i2c_slave.sv
// Top level of the serial configuration slave. Wires the input
// conditioner, the protocol engine and the register file together.
// Assumes an external pull-up on SDA and that sda_i is the resolved bus.
module cfg_i2c_slave
    import cfg_i2c_pkg::*;
#(
    parameter int NUM_BIAS    = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    input  logic [ID_W-1:0]            strap_id,
    input  logic                       fifo_err,
    input  logic                       lat_err,
    output logic                       sda_oe,
    output logic [2:0]                 mode_q,
    output logic [BYTE_W-1:0]          latency_q,
    output logic [NUM_BIAS*BYTE_W-1:0] bias_q
);
    logic              scl_s;
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic [BYTE_W-1:0] cmd_q;
    logic              wr_stb;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] rd_data;

    cfg_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    cfg_i2c_engine u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .strap_id  (strap_id),
        .rd_data   (rd_data),
        .sda_oe    (sda_oe),
        .cmd_q     (cmd_q),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data)
    );

    cfg_i2c_regfile #(.NUM_BIAS(NUM_BIAS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .wr_sel    (cmd_q[BYTE_W-1:1]),
        .wr_data   (wr_data),
        .rd_sel    (cmd_q[BYTE_W-1:1]),
        .fifo_err  (fifo_err),
        .lat_err   (lat_err),
        .mode_q    (mode_q),
        .latency_q (latency_q),
        .bias_flat (bias_q),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/cfg_i2c_checker.sv
// Protocol and register checker bound to cfg_i2c_slave.
// Assumes the internal edge, condition and strobe nets of the top level.
module cfg_i2c_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_fall,
    input logic       start_det,
    input logic       stop_det,
    input logic       sda_oe,
    input logic       wr_stb,
    input logic [7:0] cmd_q,
    input logic [2:0] mode_q,
    input logic [7:0] latency_q
);
    // R2: SDA drive only moves after an SCL fall or a bus condition.
    a_r2_oe_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));

    // R6: SDA is released once a STOP is seen.
    a_r6_release_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_det) |-> !sda_oe);

    // R3: the mode register changes only through a write strobe.
    a_r3_mode_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_q) |-> $past(wr_stb));

    // R3: the latency register changes only through a write strobe.
    a_r3_latency_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(latency_q) |-> $past(wr_stb));

    // R5: a pointer loaded for reading never produces a write.
    a_r5_no_write_on_read_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !cmd_q[0]);
endmodule

bind cfg_i2c_slave cfg_i2c_checker u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .wr_stb    (wr_stb),
    .cmd_q     (cmd_q),
    .mode_q    (mode_q),
    .latency_q (latency_q)
);

// File: tb/test_cfg_i2c_slave.sv
module test_cfg_i2c_slave;
    localparam int CLK_NS   = 10;
    localparam int HALF     = 8;
    localparam int NB       = 11;
    localparam int WD_LIMIT = 150000;

    localparam logic [6:0] ADDR_A    = 7'b001_0101;
    localparam logic [6:0] ADDR_B    = 7'b001_0011;
    localparam logic [6:0] ADDR_ALL  = 7'b001_1111;
    localparam logic [6:0] ADDR_MISS = 7'b001_1000;
    localparam logic [6:0] ADDR_BADP = 7'b011_0101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic fifo_err = 1'b0;
    logic lat_err = 1'b0;
    logic sda_bus;
    logic oe_a, oe_b;
    logic [2:0] mode_a, mode_b;
    logic [7:0] lat_a, lat_b;
    logic [NB*8-1:0] bias_a, bias_b;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic cmp_en = 1'b0;
    logic done = 1'b0;

    // Reference model state for device 0 (A) and 1 (B).
    logic [2:0] m_mode [2];
    logic [7:0] m_lat [2];
    logic [7:0] m_bias [2][NB];

    always #(CLK_NS/2) clk = ~clk;
    assign sda_bus = sda_m & ~oe_a & ~oe_b;

    cfg_i2c_slave i_cfg_i2c_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .strap_id(4'b0101), .fifo_err(fifo_err), .lat_err(lat_err),
        .sda_oe(oe_a), .mode_q(mode_a), .latency_q(lat_a), .bias_q(bias_a)
    );

    cfg_i2c_slave i_cfg_i2c_slave_b (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .strap_id(4'b0011), .fifo_err(1'b0), .lat_err(1'b0),
        .sda_oe(oe_b), .mode_q(mode_b), .latency_q(lat_b), .bias_q(bias_b)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, got, exp);
        end
    endtask

    function automatic logic [NB*8-1:0] model_flat(input int dev);
        logic [NB*8-1:0] f;
        for (int k = 0; k < NB; k++) f[k*8 +: 8] = m_bias[dev][k];
        return f;
    endfunction

    function automatic logic [7:0] model_rd(input int dev, input logic [6:0] sel);
        logic [7:0] v;
        v = 8'h00;
        if (sel == 7'h00) v = (dev == 0) ? {6'b0, ~fifo_err, ~lat_err} : 8'h03;
        else if (sel == 7'h01) v = {5'b0, m_mode[dev]};
        else if (sel == 7'h02) v = m_lat[dev];
        else if (sel >= 7'h20 && sel < 7'h20 + 7'(NB)) v = m_bias[dev][int'(sel) - 32];
        return v;
    endfunction

    task automatic model_wr(input int dev, input logic [6:0] sel, input logic [7:0] d);
        if (sel == 7'h01) m_mode[dev] = d[2:0];
        else if (sel == 7'h02) m_lat[dev] = d;
        else if (sel >= 7'h20 && sel < 7'h20 + 7'(NB)) m_bias[dev][int'(sel) - 32] = d;
    endtask

    // Per-clock comparison of register outputs and idle bus drive.
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            chk("R3 mode A", int'(mode_a), int'(m_mode[0]));
            chk("R3 latency A", int'(lat_a), int'(m_lat[0]));
            chk("R8 bias A", (bias_a == model_flat(0)) ? 1 : 0, 1);
            chk("R3 mode B", int'(mode_b), int'(m_mode[1]));
            chk("R3 latency B", int'(lat_b), int'(m_lat[1]));
            chk("R8 bias B", (bias_b == model_flat(1)) ? 1 : 0, 1);
            chk("R4 idle SDA released", int'(oe_a | oe_b), 0);
        end
    end

    // Watchdog: cycle count and hung-run termination.
    always @(posedge clk) begin
        cycles++;
        if (cycles == WD_LIMIT && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual cycles=%0d expected < %0d", cycles, WD_LIMIT);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wait_clk(HALF);
        sda_m = 1'b0; wait_clk(HALF);
        scl_m = 1'b0; wait_clk(HALF);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(HALF);
        scl_m = 1'b1; wait_clk(HALF);
        sda_m = 1'b1; wait_clk(HALF);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wait_clk(HALF);
        scl_m = 1'b1; wait_clk(HALF);
        scl_m = 1'b0;
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; wait_clk(HALF);
        scl_m = 1'b1; wait_clk(HALF/2);
        b = sda_bus;
        wait_clk(HALF - HALF/2);
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(ack);
    endtask

    task automatic recv_byte(output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(1'b1);
    endtask

    // Write transfer of nbytes (2 or 3) after the address; acks[i] per byte.
    task automatic xfer_wr(input logic [6:0] a, input logic [7:0] c,
                           input logic [7:0] d, input logic [7:0] extra,
                           input int nbytes, output logic [3:0] acks);
        logic ak;
        cmp_en = 1'b0;
        acks = 4'b1111;
        bus_start();
        send_byte({a, 1'b0}, ak); acks[0] = ak;
        send_byte(c, ak); acks[1] = ak;
        if (nbytes >= 3) begin send_byte(d, ak); acks[2] = ak; end
        if (nbytes >= 4) begin send_byte(extra, ak); acks[3] = ak; end
        bus_stop();
    endtask

    task automatic xfer_rd(input logic [6:0] a, output logic [7:0] d, output logic ak);
        cmp_en = 1'b0;
        bus_start();
        send_byte({a, 1'b1}, ak);
        recv_byte(d);
        bus_stop();
    endtask

    task automatic settle();
        wait_clk(4);
        cmp_en = 1'b1;
        wait_clk(4);
    endtask

    task automatic reg_write(input int dev, input logic [6:0] a, input logic [6:0] sel,
                             input logic [7:0] d, input string req);
        logic [3:0] acks;
        xfer_wr(a, {sel, 1'b0}, d, 8'h00, 3, acks);
        chk({req, " write acks"}, int'(acks[2:0]), 0);
        if (dev == 0 || dev == 2) model_wr(0, sel, d);
        if (dev == 1 || dev == 2) model_wr(1, sel, d);
        settle();
    endtask

    task automatic reg_read(input int dev, input logic [6:0] a, input logic [6:0] sel,
                            input string req);
        logic [3:0] acks;
        logic [7:0] d;
        logic ak;
        logic [7:0] exp;
        xfer_wr(a, {sel, 1'b1}, 8'h00, 8'h00, 2, acks);
        chk({req, " cmd acks"}, int'(acks[1:0]), 0);
        settle();
        xfer_rd(a, d, ak);
        chk({req, " read ack"}, int'(ak), 0);
        exp = (dev == 2) ? (model_rd(0, sel) & model_rd(1, sel)) : model_rd(dev, sel);
        chk({req, " read data"}, int'(d), int'(exp));
        settle();
    endtask

    initial begin
        logic [3:0] acks;
        logic [7:0] d;
        logic ak;
        for (int v = 0; v < 2; v++) begin
            m_mode[v] = 3'b100;
            m_lat[v] = 8'h84;
            for (int k = 0; k < NB; k++) m_bias[v][k] = 8'h00;
        end
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);

        // R1: reset values.
        chk("R1 mode", int'(mode_a), 4);
        chk("R1 latency", int'(lat_a), 8'h84);
        chk("R1 bias", (bias_a == '0) ? 1 : 0, 1);
        chk("R1 sda released", int'(oe_a), 0);
        settle();

        // R2, R3: addressed latency write.
        reg_write(0, ADDR_A, 7'h02, 8'h20, "R2 R3 latency");

        // R4: wrong strap and wrong prefix are not acknowledged; no change.
        xfer_wr(ADDR_MISS, 8'h04, 8'h99, 8'h00, 3, acks);
        chk("R4 foreign strap nack", int'(acks[2:0]), 7);
        settle();
        xfer_wr(ADDR_BADP, 8'h04, 8'h99, 8'h00, 3, acks);
        chk("R4 bad prefix nack", int'(acks[2:0]), 7);
        settle();

        // R6: read back latency.
        reg_read(0, ADDR_A, 7'h02, "R6 latency");

        // R7: second read without a new command.
        xfer_rd(ADDR_A, d, ak);
        chk("R7 repeat read data", int'(d), 8'h20);
        settle();

        // R5: extra byte after a read command is acknowledged but ignored.
        xfer_wr(ADDR_A, 8'h05, 8'h5A, 8'hC3, 4, acks);
        chk("R5 extra bytes acked", int'(acks), 0);
        settle();
        xfer_rd(ADDR_A, d, ak);
        chk("R5 latency unchanged", int'(d), 8'h20);
        settle();

        // R8: every bias word, both devices with different patterns.
        for (int k = 0; k < NB; k++) begin
            reg_write(0, ADDR_A, 7'h20 + 7'(k), 8'(8'h11 * (k + 1)), "R8 bias A");
            reg_write(1, ADDR_B, 7'h20 + 7'(k), 8'(8'hA5 ^ (k * 8'h13)), "R8 bias B");
        end
        reg_read(0, ADDR_A, 7'h23, "R8 bias3");
        reg_read(0, ADDR_A, 7'h2A, "R8 bias10");

        // R9: mode stores three bits only.
        reg_write(0, ADDR_A, 7'h01, 8'h03, "R9 mode");
        reg_read(0, ADDR_A, 7'h01, "R9 mode");
        reg_write(0, ADDR_A, 7'h01, 8'hFA, "R9 mode upper");
        reg_read(0, ADDR_A, 7'h01, "R9 mode upper");

        // R10: active-low error view, write to it ignored.
        fifo_err = 1'b0; lat_err = 1'b0;
        reg_read(0, ADDR_A, 7'h00, "R10 no fault");
        fifo_err = 1'b1;
        xfer_rd(ADDR_A, d, ak);
        chk("R10 fifo fault", int'(d), 8'h01);
        settle();
        lat_err = 1'b1;
        xfer_rd(ADDR_A, d, ak);
        chk("R10 both faults", int'(d), 8'h00);
        settle();
        fifo_err = 1'b0;
        xfer_rd(ADDR_A, d, ak);
        chk("R10 latency fault", int'(d), 8'h02);
        settle();
        lat_err = 1'b0;
        reg_write(0, ADDR_A, 7'h00, 8'hFF, "R10 error write");
        reg_read(0, ADDR_A, 7'h00, "R10 after write");

        // R11: broadcast write reaches both devices.
        reg_write(2, ADDR_ALL, 7'h02, 8'h40, "R11 broadcast");
        chk("R11 latency A", int'(lat_a), 8'h40);
        chk("R11 latency B", int'(lat_b), 8'h40);

        // R12: broadcast read returns the AND of both devices.
        reg_read(2, ADDR_ALL, 7'h20, "R12 wired AND bias0");
        reg_read(2, ADDR_ALL, 7'h25, "R12 wired AND bias5");
        reg_read(1, ADDR_B, 7'h20, "R12 B alone");

        // R13: unknown code stores nothing and reads zero.
        reg_write(0, ADDR_A, 7'h30, 8'hAB, "R13 unknown");
        reg_read(0, ADDR_A, 7'h30, "R13 unknown");

        wait_clk(10);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule